// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that counts a slow, low-power tick strobe. Each accepted tick advances a prescaler with a selectable length of 32 or 128 ticks. Every wrap of the prescaler advances a postscaler, whose ratio is 2^n for a 4-bit select n. When the postscaler reaches its terminal count, the period has expired. The watchdog runs at all times when the hard-enable configuration bit is set. Otherwise it runs only while a software enable bit, held inside the block, is set. That bit is cleared by every system reset.

Software keeps the watchdog quiet by pulsing a clear strobe. In windowed mode a clear is accepted only during the last quarter of the period. A clear that comes earlier is treated as a fault and raises the same reset request as an expired period. The count also restarts when the core enters sleep or idle and when the clock source changes. If the period expires while the core sleeps, the block emits a wake pulse instead of a reset request. A sticky status flag records every expiry and every early clear until the next system reset.

All inputs are single-cycle strobes or static levels in the system clock domain. The block has no streaming data path, so no valid/ready handshake is involved.

Top module: `winwdt`

## Requirements
- R1: After system reset (rst_n low), rst_req, wake and to_flag are 0, the counts are zero and the software enable bit is 0.
- R2: With cfg_hard_en = 1 the watchdog runs regardless of the software enable bit. With cfg_hard_en = 0 it runs only while the software enable bit is 1. That bit is written with sw_en_d on a cycle where sw_en_we = 1. While the watchdog is stopped its count is held at zero, and tick and clr have no effect.
- R3: cfg_long_pre = 0 selects a prescaler length of 32 ticks, and cfg_long_pre = 1 selects 128 ticks.
- R4: The period is (prescaler length) × 2^cfg_post_sel ticks. A tick that completes the period while sleeping = 0 produces a one-cycle rst_req pulse in the cycle after that tick, and the count restarts from zero.
- R5: Windowed mode is active when cfg_win_n = 0. In that mode, a clr that arrives when the elapsed tick count is at least three quarters of the period restarts the count without any request.
- R6: In windowed mode, a clr that arrives when the elapsed count is below three quarters of the period produces a one-cycle rst_req pulse in the next cycle and restarts the count.
- R7: With cfg_win_n = 1, a clr at any elapsed count restarts the count and never produces a request.
- R8: A rising edge of sleeping and a clk_chg strobe each restart the count from zero.
- R9: A tick that completes the period while sleeping = 1 produces a one-cycle wake pulse in the next cycle and no rst_req.
- R10: to_flag is set together with any rst_req or wake pulse and stays set until the next system reset.
- R11: A clr, clk_chg or sleep entry in the same cycle as a tick takes precedence. That tick is not counted and cannot complete the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| tick | input | 1 | One-cycle strobe from the low-power tick source |
| cfg_hard_en | input | 1 | 1: watchdog always runs |
| cfg_win_n | input | 1 | 0: windowed clear checking active |
| cfg_long_pre | input | 1 | Prescaler length select (0: 32, 1: 128 ticks) |
| cfg_post_sel | input | 4 | Postscaler ratio exponent n, ratio 2^n |
| sw_en_we | input | 1 | Write strobe for the software enable bit |
| sw_en_d | input | 1 | Value written to the software enable bit |
| clr | input | 1 | Clear strobe from software |
| sleeping | input | 1 | Core is in sleep or idle |
| clk_chg | input | 1 | Strobe on a clock-source change |
| rst_req | output | 1 | One-cycle reset request (timeout or early clear) |
| wake | output | 1 | One-cycle wake pulse (timeout during sleep) |
| to_flag | output | 1 | Sticky timeout/early-clear status |

## Verification
The checker's assertions hold on every cycle. They check that rst_req and wake never coincide, that wake follows only a cycle spent sleeping, that a stopped watchdog stays quiet, and that a clear outside windowed mode never requests a reset. They also check that to_flag rises with every event and then holds. The exact tick count to an expiry for each prescaler and postscaler setting, the position of the window boundary, and the restart on sleep entry or clock change can only be shown by the bench's scenarios. The same applies to the precedence of a clear over a coinciding tick. The bench compares each of these cycle by cycle against its own model of elapsed ticks.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  // Default sizing of the watchdog chain
  localparam int unsigned PRE_SHORT_W = 5;   // short prescaler: 2^5 ticks
  localparam int unsigned PRE_LONG_W  = 7;   // long prescaler: 2^7 ticks
  localparam int unsigned POST_SEL_W  = 4;   // ratio exponent field width
  localparam int unsigned POST_CNT_W  = (1 << POST_SEL_W) - 1;
  localparam int unsigned ELAP_W      = PRE_LONG_W + POST_CNT_W;
endpackage

// File: rtl/wwdt_prescaler.sv
module wwdt_prescaler #(
  parameter int unsigned SHORT_W = wwdt_pkg::PRE_SHORT_W,
  parameter int unsigned LONG_W  = wwdt_pkg::PRE_LONG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  input  logic              long_sel,
  output logic [LONG_W-1:0] cnt,
  output logic              wrap
);
  localparam logic [LONG_W-1:0] TERM_SHORT = LONG_W'((1 << SHORT_W) - 1);
  localparam logic [LONG_W-1:0] TERM_LONG  = {LONG_W{1'b1}};

  logic [LONG_W-1:0] term;

  assign term = long_sel ? TERM_LONG : TERM_SHORT;
  assign wrap = step && (cnt == term);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (step)    cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/wwdt_postscaler.sv
module wwdt_postscaler #(
  parameter int unsigned SEL_W = wwdt_pkg::POST_SEL_W,
  localparam int unsigned CW   = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             adv,
  input  logic [SEL_W-1:0] sel,
  output logic [CW-1:0]    cnt,
  output logic             done
);
  logic [CW-1:0] term;

  // Terminal count 2^sel - 1: every bit below the select is set
  for (genvar i = 0; i < CW; i++) begin : g_term
    assign term[i] = (int'(sel) > i);
  end

  assign done = adv && (cnt == term);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (adv)     cnt <= done ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/wwdt_window.sv
module wwdt_window #(
  parameter int unsigned SHORT_W = wwdt_pkg::PRE_SHORT_W,
  parameter int unsigned LONG_W  = wwdt_pkg::PRE_LONG_W,
  parameter int unsigned SEL_W   = wwdt_pkg::POST_SEL_W,
  localparam int unsigned CW     = (1 << SEL_W) - 1,
  localparam int unsigned EW     = LONG_W + CW
) (
  input  logic              long_sel,
  input  logic [SEL_W-1:0]  sel,
  input  logic [LONG_W-1:0] pre_cnt,
  input  logic [CW-1:0]     post_cnt,
  output logic              open
);
  logic [EW-1:0] elapsed;
  logic [EW-1:0] thr;
  int            kk;

  // Total elapsed ticks = post_cnt * prescaler length + pre_cnt.
  // The period is 2^kk, so three quarters of it is 3 << (kk-2).
  always_comb begin
    if (long_sel) begin
      elapsed = {post_cnt, pre_cnt};
      kk      = int'(LONG_W) + int'(sel);
    end else begin
      elapsed = EW'({post_cnt, pre_cnt[SHORT_W-1:0]});
      kk      = int'(SHORT_W) + int'(sel);
    end
    thr  = EW'(3) << (kk - 2);
    open = (elapsed >= thr);
  end
endmodule

// File: rtl/wwdt_ctrl.sv
module wwdt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hard_en,
  input  logic win_n,
  input  logic sw_we,
  input  logic sw_d,
  input  logic clr,
  input  logic sleeping,
  input  logic clk_chg,
  input  logic tick,
  input  logic win_open,
  input  logic timeout,
  output logic restart,
  output logic step,
  output logic sw_q,
  output logic rst_req,
  output logic wake,
  output logic flag
);
  logic run;
  logic slp_q;
  logic slp_rise;
  logic clr_hit;
  logic early;

  assign run      = hard_en | sw_q;
  assign slp_rise = sleeping & ~slp_q;
  assign clr_hit  = run & clr;
  assign early    = clr_hit & ~win_n & ~win_open;
  assign restart  = ~run | clr_hit | slp_rise | clk_chg;
  assign step     = tick & ~restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q    <= 1'b0;
      slp_q   <= 1'b0;
      rst_req <= 1'b0;
      wake    <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (sw_we) sw_q <= sw_d;
      slp_q   <= sleeping;
      rst_req <= early | (timeout & ~sleeping);
      wake    <= timeout & sleeping;
      flag    <= flag | early | timeout;
    end
  end
endmodule

// File: rtl/winwdt.sv
module winwdt #(
  parameter int unsigned SHORT_W = wwdt_pkg::PRE_SHORT_W,
  parameter int unsigned LONG_W  = wwdt_pkg::PRE_LONG_W,
  parameter int unsigned SEL_W   = wwdt_pkg::POST_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfg_hard_en,
  input  logic             cfg_win_n,
  input  logic             cfg_long_pre,
  input  logic [SEL_W-1:0] cfg_post_sel,
  input  logic             sw_en_we,
  input  logic             sw_en_d,
  input  logic             clr,
  input  logic             sleeping,
  input  logic             clk_chg,
  output logic             rst_req,
  output logic             wake,
  output logic             to_flag
);
  localparam int unsigned CW = (1 << SEL_W) - 1;

  logic              restart;
  logic              step;
  logic              sw_q;
  logic              pre_wrap;
  logic              timeout;
  logic              win_open;
  logic [LONG_W-1:0] pre_cnt;
  logic [CW-1:0]     post_cnt;

  wwdt_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .hard_en  (cfg_hard_en),
    .win_n    (cfg_win_n),
    .sw_we    (sw_en_we),
    .sw_d     (sw_en_d),
    .clr      (clr),
    .sleeping (sleeping),
    .clk_chg  (clk_chg),
    .tick     (tick),
    .win_open (win_open),
    .timeout  (timeout),
    .restart  (restart),
    .step     (step),
    .sw_q     (sw_q),
    .rst_req  (rst_req),
    .wake     (wake),
    .flag     (to_flag)
  );

  wwdt_prescaler #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .step     (step),
    .long_sel (cfg_long_pre),
    .cnt      (pre_cnt),
    .wrap     (pre_wrap)
  );

  wwdt_postscaler #(.SEL_W(SEL_W)) u_post (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .adv     (pre_wrap),
    .sel     (cfg_post_sel),
    .cnt     (post_cnt),
    .done    (timeout)
  );

  wwdt_window #(.SHORT_W(SHORT_W), .LONG_W(LONG_W), .SEL_W(SEL_W)) u_win (
    .long_sel (cfg_long_pre),
    .sel      (cfg_post_sel),
    .pre_cnt  (pre_cnt),
    .post_cnt (post_cnt),
    .open     (win_open)
  );
endmodule

// File: rtl/winwdt_chk.sv
module winwdt_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_hard_en,
  input logic cfg_win_n,
  input logic clr,
  input logic sleeping,
  input logic sw_q,
  input logic rst_req,
  input logic wake,
  input logic to_flag
);
  p_quiet_when_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_hard_en && !sw_q) |=> (!rst_req && !wake));

  p_open_clear_safe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_win_n && clr) |=> !rst_req);

  p_wake_needs_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(sleeping));

  p_no_dual_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && wake));

  p_event_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || wake) |-> to_flag);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    to_flag |=> to_flag);
endmodule

bind winwdt winwdt_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_hard_en (cfg_hard_en),
  .cfg_win_n   (cfg_win_n),
  .clr         (clr),
  .sleeping    (sleeping),
  .sw_q        (sw_q),
  .rst_req     (rst_req),
  .wake        (wake),
  .to_flag     (to_flag)
);

// File: tb/winwdt_test.sv
`timescale 1ns/1ps
module winwdt_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, cfg_hard_en = 1'b1, cfg_win_n = 1'b1, cfg_long_pre = 1'b0;
  logic [3:0] cfg_post_sel = 4'd0;
  logic       sw_en_we = 1'b0, sw_en_d = 1'b0, clr = 1'b0, sleeping = 1'b0, clk_chg = 1'b0;
  logic       rst_req, wake, to_flag;

  int vectors = 0;
  int errors  = 0;
  string tag  = "R1";

  // reference model state
  int m_el = 0;
  bit m_swq = 0, m_slp = 0, m_flag = 0, e_rst = 0, e_wake = 0;

  always #2.5 clk = ~clk;

  winwdt uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_hard_en(cfg_hard_en),
    .cfg_win_n(cfg_win_n), .cfg_long_pre(cfg_long_pre), .cfg_post_sel(cfg_post_sel),
    .sw_en_we(sw_en_we), .sw_en_d(sw_en_d), .clr(clr), .sleeping(sleeping),
    .clk_chg(clk_chg), .rst_req(rst_req), .wake(wake), .to_flag(to_flag)
  );

  function automatic int period(bit lg, logic [3:0] s);
    return (lg ? 128 : 32) << s;
  endfunction

  task automatic check(string t, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", t, what, got, exp);
    end
  endtask

  // Predict outputs after the coming clock edge from the inputs now applied
  task automatic model_step();
    bit run, rise, er, ew;
    int per;
    er = 0; ew = 0;
    if (!rst_n) begin
      m_el = 0; m_swq = 0; m_slp = 0; m_flag = 0;
    end else begin
      run  = cfg_hard_en | m_swq;
      per  = period(cfg_long_pre, cfg_post_sel);
      rise = sleeping && !m_slp;
      if (run && clr && !cfg_win_n && (m_el * 4 < 3 * per)) er = 1;
      if (!run || clr || rise || clk_chg) m_el = 0;
      else if (tick) begin
        if (m_el == per - 1) begin
          m_el = 0;
          if (sleeping) ew = 1; else er = 1;
        end else m_el++;
      end
      m_flag = m_flag | er | ew;
      m_slp  = sleeping;
      if (sw_en_we) m_swq = sw_en_d;
    end
    e_rst = er; e_wake = ew;
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk);
    check(tag, "rst_req", int'(rst_req), int'(e_rst));
    check(tag, "wake", int'(wake), int'(e_wake));
    check(tag, "to_flag", int'(to_flag), int'(m_flag));
    tick = 0; clr = 0; clk_chg = 0; sw_en_we = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick = 1; cyc(); end
  endtask

  task automatic do_reset();
    rst_n = 0; cyc(); cyc(); rst_n = 1;
  endtask

  // Count ticks until rst_req appears and compare with the period
  task automatic measure(bit lg, logic [3:0] s, string t);
    int n;
    bit got;
    cfg_long_pre = lg; cfg_post_sel = s; clk_chg = 1; cyc();
    n = 0; got = 0;
    while (!got && n < 5000) begin
      tick = 1; cyc(); n++;
      if (rst_req) got = 1;
    end
    check(t, "ticks to timeout", n, period(lg, s));
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    tag = "R1";
    do_reset();
    check("R1", "rst_req after reset", int'(rst_req), 0);
    check("R1", "to_flag after reset", int'(to_flag), 0);

    // R3/R4: period lengths for both prescalers and several ratios
    cfg_hard_en = 1; cfg_win_n = 1;
    tag = "R4";
    for (int s = 0; s < 3; s++) measure(1'b0, 4'(s), "R4");
    tag = "R3";
    measure(1'b1, 4'd0, "R3");
    measure(1'b1, 4'd1, "R3");

    // R2: software enable, ignored under hard enable
    tag = "R2";
    do_reset();
    cfg_hard_en = 0; cfg_long_pre = 0; cfg_post_sel = 0;
    ticks(40); clr = 1; cyc();
    check("R2", "stopped flag", int'(to_flag), 0);
    sw_en_we = 1; sw_en_d = 1; cyc();
    ticks(32);
    check("R2", "sw-enabled timeout", int'(rst_req), 1);
    sw_en_we = 1; sw_en_d = 0; cyc();
    cfg_hard_en = 1;
    measure(1'b0, 4'd0, "R2");

    // R6 / R5: window boundary at 3/4 of 128 ticks
    cfg_win_n = 0; cfg_post_sel = 2; clk_chg = 1; cyc();
    tag = "R6";
    ticks(95); clr = 1; cyc();
    check("R6", "early clear request", int'(rst_req), 1);
    tag = "R5";
    ticks(96); clr = 1; cyc();
    check("R5", "in-window clear", int'(rst_req), 0);
    ticks(127);
    check("R5", "restarted by clear", int'(rst_req), 0);
    ticks(1);
    check("R5", "timeout after restart", int'(rst_req), 1);

    // R7: non-window clear early
    tag = "R7";
    cfg_win_n = 1; ticks(3); clr = 1; cyc();
    check("R7", "open clear", int'(rst_req), 0);

    // R8: clock change and sleep entry restart
    tag = "R8";
    cfg_post_sel = 0; clk_chg = 1; cyc();
    ticks(20); clk_chg = 1; cyc(); ticks(31);
    check("R8", "no timeout after clk_chg", int'(rst_req), 0);
    ticks(10); sleeping = 1; cyc(); sleeping = 0; ticks(31);
    check("R8", "no timeout after sleep entry", int'(rst_req), 0);
    ticks(1);
    check("R8", "timeout after full period", int'(rst_req), 1);

    // R9: timeout during sleep gives wake
    tag = "R9";
    sleeping = 1; cyc(); ticks(32);
    check("R9", "wake", int'(wake), 1);
    check("R9", "no reset request", int'(rst_req), 0);
    sleeping = 0; cyc();

    // R11: clear in the same cycle as the completing tick
    tag = "R11";
    clk_chg = 1; cyc(); ticks(31); tick = 1; clr = 1; cyc();
    check("R11", "clear beats tick", int'(rst_req), 0);
    ticks(31);
    check("R11", "count restarted", int'(rst_req), 0);

    // R10: flag persists, reset clears it
    tag = "R10";
    repeat (20) cyc();
    check("R10", "flag held", int'(to_flag), 1);
    do_reset();
    check("R1", "flag cleared by reset", int'(to_flag), 0);

    // Random mix against the model
    tag = "R4";
    begin
      int unsigned seed;
      seed = 32'h1d2c;
      void'($urandom(seed));
    end
    for (int i = 0; i < 6000; i++) begin
      tick = ($urandom_range(3) != 0);
      if ($urandom_range(60) == 0) begin
        clk_chg = 1;
        cfg_long_pre = $urandom_range(1);
        cfg_post_sel = 4'($urandom_range(2));
        cfg_win_n = $urandom_range(1);
      end else begin
        clr = ($urandom_range(50) == 0);
        clk_chg = ($urandom_range(200) == 0);
      end
      if ($urandom_range(150) == 0) cfg_hard_en = $urandom_range(1);
      if ($urandom_range(80) == 0) begin sw_en_we = 1; sw_en_d = $urandom_range(1); end
      if ($urandom_range(100) == 0) sleeping = ~sleeping;
      if ($urandom_range(1500) == 0) rst_n = 0; else rst_n = 1;
      cyc();
    end
    rst_n = 1;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule